// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations. A virtual address is made of a 19-bit virtual page number and a 12-bit page offset. Each lookup compares the page number against every stored entry at once. On a match the block returns the stored 15-bit physical page number, joined with the offset that passes through unchanged, in the same cycle as the request. No memory is accessed on a match.

When a lookup misses, an external walker fetches the translation and installs it through a fill port. If the page number is already stored, the fill rewrites that entry. Otherwise the fill picks a slot in this order:
1. an empty slot;
2. a slot whose recently-used flag is clear;
3. slot 0.

Every hit and every fill sets the recently-used flag of its slot. A pulse input clears all of these flags, and a flush input empties the whole buffer.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so every lookup misses and `lkp_hit_o` is 0.
- R2: A lookup whose page number matches a stored entry raises `lkp_hit_o` combinationally in the request cycle. In that case `lkp_paddr_o` equals {stored physical page, vaddr[11:0]}, with the physical page in bits 26:12.
- R3: On a miss, `lkp_paddr_o[26:12]` is 0 and `lkp_paddr_o[11:0]` still equals vaddr[11:0].
- R4: A fill takes effect at the next rising clock edge, and a lookup in any later cycle hits with the filled physical page. Slot occupancy changes only by fill or flush.
- R5: A fill whose page number is already stored rewrites that slot's physical page. No duplicate is created, and every other stored entry remains.
- R6: When at least one slot is empty, a new page number is written to the lowest-index empty slot. Filling an empty buffer therefore uses slots 0, 1, 2, … in order.
- R7: When all slots are occupied, a new page number replaces the lowest-index slot whose recently-used flag is clear.
- R8: When all slots are occupied and all recently-used flags are set, a new page number replaces slot 0.
- R9: A hitting lookup sets the recently-used flag of its slot, and so does a fill.
- R10: `clr_use_i` clears every recently-used flag. A hit or fill in the same cycle still sets its own flag after the clear.
- R11: `flush_i` empties every slot and clears every flag. A fill in the same cycle is discarded.
- R12: A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 31 | Virtual address: page number in 30:12, offset in 11:0 |
| lkp_hit_o | output | 1 | Lookup matched a stored entry |
| lkp_paddr_o | output | 27 | Physical address: page in 26:12, offset in 11:0 |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 19 | Virtual page number to install |
| fill_ppn_i | input | 15 | Physical page number to install |
| clr_use_i | input | 1 | Clear all recently-used flags |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The hardest state to reach is a full buffer with a chosen pattern of recently-used flags, because the flags are never visible at the ports. The stimulus builds this state in several steps:
- fill all sixteen slots in order;
- pulse the flag clear;
- touch a prefix of slots with hitting lookups;
- issue a new fill.

The lookups that follow reveal which page number was evicted, and that shows which slot the fill chose. The same approach, combined with a clear pulse that coincides with a hit, checks that the same-cycle set takes priority over the clear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VPN_W = 19;
  localparam int unsigned TLB_PPN_W = 15;
  localparam int unsigned TLB_OFF_W = 12;
  localparam int unsigned TLB_DEPTH = 16;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 19,
  parameter int unsigned IDX_W = 4
) (
  input  logic [VPN_W-1:0]             key_i,
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0][VPN_W-1:0]  vpn_i,
  output logic [DEPTH-1:0]             match_o,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] use_i,
  output logic [IDX_W-1:0] idx_o
);
  // later loop wins: empty slot beats unused slot, default slot 0
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!use_i[i]) idx_o = IDX_W'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 19,
  parameter int unsigned PPN_W = 15,
  parameter int unsigned IDX_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [VPN_W-1:0]             wr_vpn_i,
  input  logic [PPN_W-1:0]             wr_ppn_i,
  input  logic                         look_en_i,
  input  logic [IDX_W-1:0]             look_idx_i,
  input  logic                         clr_use_i,
  input  logic                         flush_i,
  output logic [DEPTH-1:0]             valid_o,
  output logic [DEPTH-1:0]             use_o,
  output logic [DEPTH-1:0][VPN_W-1:0]  vpn_o,
  output logic [DEPTH-1:0][PPN_W-1:0]  ppn_o
);
  logic [DEPTH-1:0] valid_q, use_q, touch_mask;

  always_comb begin
    touch_mask = '0;
    if (look_en_i) touch_mask[look_idx_i] = 1'b1;
    if (wr_en_i)   touch_mask[wr_idx_i]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      use_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      use_q   <= '0;
    end else begin
      use_q <= (clr_use_i ? '0 : use_q) | touch_mask;
      if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_o[g] <= '0;
        ppn_o[g] <= '0;
      end else if (wr_en_i && !flush_i && (wr_idx_i == IDX_W'(g))) begin
        vpn_o[g] <= wr_vpn_i;
        ppn_o[g] <= wr_ppn_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign use_o   = use_q;

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0) && (use_q == '0)); // R11
  AST_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i |=> valid_q[$past(wr_idx_i)] && use_q[$past(wr_idx_i)]); // R9
  AST_CLR_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_use_i && !flush_i |=> ((use_q & ~$past(touch_mask)) == '0)); // R10
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i && !wr_en_i |=> valid_q == $past(valid_q)); // R4
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W = TLB_VPN_W,
  parameter int unsigned PPN_W = TLB_PPN_W,
  parameter int unsigned OFF_W = TLB_OFF_W,
  parameter int unsigned DEPTH = TLB_DEPTH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lkp_valid_i,
  input  logic [VPN_W+OFF_W-1:0]   lkp_vaddr_i,
  output logic                     lkp_hit_o,
  output logic [PPN_W+OFF_W-1:0]   lkp_paddr_o,
  input  logic                     fill_valid_i,
  input  logic [VPN_W-1:0]         fill_vpn_i,
  input  logic [PPN_W-1:0]         fill_ppn_i,
  input  logic                     clr_use_i,
  input  logic                     flush_i
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned VA_W  = VPN_W + OFF_W;

  logic [DEPTH-1:0]            valid, use_bits, lkp_match, fill_match;
  logic [DEPTH-1:0][VPN_W-1:0] vpn_arr;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_arr;
  logic [VPN_W-1:0]            lkp_vpn;
  logic                        lkp_hit, fill_hit;
  logic [IDX_W-1:0]            lkp_idx, fill_idx, vic_idx, wr_idx;
  logic [PPN_W-1:0]            lkp_ppn;

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:OFF_W];

  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lkp_cam (
    .key_i(lkp_vpn), .valid_i(valid), .vpn_i(vpn_arr),
    .match_o(lkp_match), .hit_o(lkp_hit), .idx_o(lkp_idx)
  );

  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_cam (
    .key_i(fill_vpn_i), .valid_i(valid), .vpn_i(vpn_arr),
    .match_o(fill_match), .hit_o(fill_hit), .idx_o(fill_idx)
  );

  tlb_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
    .valid_i(valid), .use_i(use_bits), .idx_o(vic_idx)
  );

  // refill of a stored page rewrites in place
  assign wr_idx = fill_hit ? fill_idx : vic_idx;

  tlb_store #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(fill_valid_i), .wr_idx_i(wr_idx),
    .wr_vpn_i(fill_vpn_i), .wr_ppn_i(fill_ppn_i),
    .look_en_i(lkp_valid_i && lkp_hit), .look_idx_i(lkp_idx),
    .clr_use_i(clr_use_i), .flush_i(flush_i),
    .valid_o(valid), .use_o(use_bits), .vpn_o(vpn_arr), .ppn_o(ppn_arr)
  );

  assign lkp_ppn     = lkp_hit ? ppn_arr[lkp_idx] : '0;
  assign lkp_hit_o   = lkp_valid_i && lkp_hit;
  assign lkp_paddr_o = {lkp_ppn, lkp_vaddr_i[OFF_W-1:0]};

  AST_NO_DUP_LKP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match)); // R5
  AST_NO_DUP_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_match)); // R5
  AST_VICTIM_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid) |-> !valid[vic_idx]); // R6
  AST_HIT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> valid[lkp_idx] && (vpn_arr[lkp_idx] == lkp_vpn)); // R2
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [30:0] lkp_vaddr_i = '0;
  logic        lkp_hit_o;
  logic [26:0] lkp_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [18:0] fill_vpn_i = '0;
  logic [14:0] fill_ppn_i = '0;
  logic        clr_use_i = 1'b0;
  logic        flush_i = 1'b0;

  always #5 clk_i = ~clk_i;

  tlb_fa dut (.*);

  typedef struct {
    logic        hit;
    logic [26:0] pa;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;

  logic [18:0] m_vpn [N];
  logic [14:0] m_ppn [N];
  bit          m_val [N];
  bit          m_use [N];

  function automatic int m_find(input logic [18:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    for (int i = 0; i < N; i++) if (!m_use[i]) return i;
    return 0;
  endfunction

  task automatic step(input bit lv, input logic [18:0] lvpn, input logic [11:0] off,
                      input bit fv, input logic [18:0] fvpn, input logic [14:0] fppn,
                      input bit clr, input bit fl, input string tag);
    int li, fi;
    exp_t e;
    @(posedge clk_i);
    #1;
    lkp_valid_i  = lv;
    lkp_vaddr_i  = {lvpn, off};
    fill_valid_i = fv;
    fill_vpn_i   = fvpn;
    fill_ppn_i   = fppn;
    clr_use_i    = clr;
    flush_i      = fl;
    li = m_find(lvpn);
    if (lv) begin
      e.hit = (li >= 0);
      e.pa  = {(li >= 0) ? m_ppn[li] : 15'd0, off};
      e.tag = tag;
      exp_q.push_back(e);
    end
    fi = m_find(fvpn);
    if (fi < 0) fi = m_victim();
    if (fl) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_use[i] = 0; end
    end else begin
      if (clr) for (int i = 0; i < N; i++) m_use[i] = 0;
      if (lv && li >= 0) m_use[li] = 1;
      if (fv) begin
        m_vpn[fi] = fvpn; m_ppn[fi] = fppn; m_val[fi] = 1; m_use[fi] = 1;
      end
    end
  endtask

  task automatic lk(input logic [18:0] v, input logic [11:0] off, input string tag);
    step(1, v, off, 0, '0, '0, 0, 0, tag);
  endtask

  task automatic fill(input logic [18:0] v, input logic [14:0] p);
    step(0, '0, '0, 1, v, p, 0, 0, "");
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0, 0, 0, "");
  endtask

  // monitor: compare at the falling edge of each lookup cycle
  always @(negedge clk_i) begin
    if (rst_ni && lkp_valid_i) begin
      exp_t e;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected lookup, actual hit=%0b pa=%h expected none",
                 lkp_hit_o, lkp_paddr_o);
      end else begin
        e = exp_q.pop_front();
        if (lkp_hit_o !== e.hit || lkp_paddr_o !== e.pa) begin
          n_fail++;
          $display("FAIL %s: actual hit=%0b pa=%h expected hit=%0b pa=%h",
                   e.tag, lkp_hit_o, lkp_paddr_o, e.hit, e.pa);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_use[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #3;
    n_run++;
    if (lkp_hit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual hit=%0b expected 0", lkp_hit_o);
    end
    lk(19'h0, 12'h000, "R1");
    lk(19'h5, 12'h010, "R1");
    lk(19'h12345, 12'hABC, "R3");
    // same-cycle fill and lookup: old contents seen
    step(1, 19'h0AAAA, 12'h123, 1, 19'h0AAAA, 15'h1357, 0, 0, "R12");
    lk(19'h0AAAA, 12'h123, "R4");
    lk(19'h0AAAA, 12'hFFF, "R2");
    lk(19'h0AAAB, 12'h001, "R3");
    // empty table, then fill in slot order
    step(0, '0, '0, 0, '0, '0, 0, 1, "");
    lk(19'h0AAAA, 12'h123, "R11");
    for (int i = 0; i < N; i++) fill(19'h100 + 19'(i), 15'h200 + 15'(i));
    for (int i = 0; i < N; i++) lk(19'h100 + 19'(i), 12'(i * 7), "R6");
    // refill in place
    fill(19'h103, 15'h7777);
    lk(19'h103, 12'h044, "R5");
    for (int i = 0; i < N; i++) lk(19'h100 + 19'(i), 12'h055, "R5");
    // all flags set: slot 0 replaced
    fill(19'h300, 15'h0300);
    lk(19'h100, 12'h001, "R8");
    lk(19'h300, 12'h002, "R8");
    // clear flags, touch slots 0..4, fill evicts slot 5
    step(0, '0, '0, 0, '0, '0, 1, 0, "");
    lk(19'h300, 12'h000, "R9");
    for (int i = 1; i < 5; i++) lk(19'h100 + 19'(i), 12'h000, "R9");
    fill(19'h400, 15'h0400);
    lk(19'h105, 12'h00F, "R7");
    lk(19'h400, 12'h00F, "R7");
    // fill set slot 5's flag: next victim is slot 6
    fill(19'h401, 15'h0401);
    lk(19'h106, 12'h0F0, "R9");
    lk(19'h401, 12'h0F0, "R9");
    // clear with same-cycle hit on slot 0: slot 0 keeps its flag
    step(1, 19'h300, 12'h321, 0, '0, '0, 1, 0, "R10");
    fill(19'h500, 15'h0500);
    lk(19'h300, 12'h222, "R10");
    lk(19'h101, 12'h222, "R10");
    lk(19'h500, 12'h222, "R10");
    // flush with same-cycle fill: fill discarded
    step(0, '0, '0, 1, 19'h600, 15'h0600, 0, 1, "");
    lk(19'h600, 12'h0AB, "R11");
    lk(19'h102, 12'h0AB, "R11");
    fill(19'h700, 15'h0700);
    lk(19'h700, 12'h0CD, "R6");
    idle();
    idle();
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule